// File: doc/BRIEF.md
# Segmented Counting Bloom Filter for Early Miss Detection

This block keeps a conservative record of which line addresses may be held in an inclusive second-level cache. A lookup can then declare a definite miss before the cache itself is probed. The record is split into two structures. One is a presence bit vector that answers lookups on a fast port. The other is an array of small saturating counters that is maintained at a slower rate, set by a strobe input.

Insert events are raised when the cache misses, not when the line arrives. Delete events are raised on eviction. Both kinds of event enter a short queue. The counter array takes one queued event on each slow strobe. When a counter moves between zero and non-zero, it sends a set or clear to the bit vector. The vector can only ever lag by showing a stale "maybe present"; it never shows a stale "absent".

A counter that would pass its top value is retired, and its vector bit stays set from then on. When enough counters are retired, or when an event is dropped because the queue is full, the block asks for a cache flush. Once the flush is acknowledged, all tracking state starts over.

Top module: `scbf_filter`

## Requirements
- R1: The table index is address bits [OFS_W+IDX_W-1:OFS_W], where OFS_W = log2(LINE_BYTES) and IDX_W = log2(N_ENTRIES). No other address bit affects a lookup or an update.
- R2: A lookup with `q_valid` high produces `q_resp_valid` high on the next cycle. In that cycle `q_absent` is 1 exactly when the indexed vector bit is 0. With no lookup, `q_resp_valid` and `q_absent` are 0.
- R3: After reset, every lookup reports absent and `flush_req` is 0.
- R4: Events are queued and applied one per cycle in which `slow_tick` is high, oldest first. A lookup issued two or more cycles after the tick cycle sees the result.
- R5: An insert increments the indexed 3-bit counter, and a 0 to 1 change sets the vector bit. A delete decrements it, and a 1 to 0 change clears the bit. The bit stays set while the counter is above 0.
- R6: A delete that finds its counter at 0 changes nothing.
- R7: If an insert and a delete are raised in the same cycle, the insert is queued ahead of the delete.
- R8: An insert that finds its counter at 7 retires that entry. A retired entry reports maybe present and ignores all later events. `flush_req` rises once FLUSH_THRESH entries are retired.
- R9: An event that finds no room in the FIFO_DEPTH queue is dropped. The drop sets `flush_req`, which stays high until the flush is acknowledged.
- R10: `flush_ack` while `flush_req` is high returns all counters, retired marks and vector bits to 0 and drops `flush_req`. No event is applied in that cycle, and events still queued are applied afterwards.
- R11: `flush_ack` while `flush_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Lookup strobe |
| q_addr | input | ADDR_W | Lookup address |
| q_resp_valid | output | 1 | Lookup result valid, one cycle after the lookup |
| q_absent | output | 1 | 1 = line certainly absent, 0 = maybe present |
| ins_valid | input | 1 | Insert event (raised on a cache miss) |
| ins_addr | input | ADDR_W | Insert address |
| del_valid | input | 1 | Delete event (raised on an eviction) |
| del_addr | input | ADDR_W | Delete address |
| slow_tick | input | 1 | Counter-array update strobe |
| flush_req | output | 1 | Cache flush request |
| flush_ack | input | 1 | Flush acknowledge |

## Verification
The lookup is tried with addresses that share an index but differ in the offset and upper bits, which shows that only the index field is hashed. Neighbouring indices show that entries do not leak into each other. Repeated inserts to one index, followed by an equal number of deletes, separate a true counter from a single bit. A delete against an empty entry separates an ignore from a wrap to 7. A same-cycle insert and delete to one index reveals the order in which they are queued. Eight inserts to one index reach retirement. Bursts larger than the queue exercise the dropped-event flush. A seeded random mix over a dozen colliding indices, checked against a bench model, catches errors that depend on how the operations interleave.

// File: rtl/scbf_pkg.sv
package scbf_pkg;

    localparam int CNT_W = 3;
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef enum logic {
        OP_DEL = 1'b0,
        OP_INS = 1'b1
    } op_e;

    typedef struct packed {
        logic [CNT_W-1:0] next;
        logic             write;
        logic             retire;
        logic             set_bit;
        logic             clr_bit;
    } step_t;

    function automatic step_t cnt_step(op_e op, logic [CNT_W-1:0] cur, logic retired);
        step_t s;
        s      = '0;
        s.next = cur;
        if (!retired) begin
            if (op == OP_INS) begin
                if (cur == CNT_TOP) begin
                    s.retire = 1'b1;
                end else begin
                    s.next    = cur + CNT_W'(1);
                    s.write   = 1'b1;
                    s.set_bit = (cur == '0);
                end
            end else if (cur != '0) begin
                s.next    = cur - CNT_W'(1);
                s.write   = 1'b1;
                s.clr_bit = (cur == CNT_W'(1));
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/scbf_event_fifo.sv
module scbf_event_fifo #(
    parameter int EW    = 11,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_a,
    input  logic [EW-1:0] data_a,
    input  logic          push_b,
    input  logic [EW-1:0] data_b,
    input  logic          pop,
    output logic [EW-1:0] head,
    output logic          empty,
    output logic          lost
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] used, space, n_push;
    logic          acc_a, acc_b, do_pop;

    always_comb begin
        space  = CW'(DEPTH) - used;
        acc_a  = push_a && (space != '0);
        acc_b  = push_b && (space > CW'(acc_a));
        n_push = CW'(acc_a) + CW'(acc_b);
        do_pop = pop && (used != '0);
        lost   = (push_a && !acc_a) || (push_b && !acc_b);
        empty  = (used == '0);
        head   = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (acc_a) mem[wr_ptr] <= data_a;
        if (acc_b) mem[wr_ptr + PW'(acc_a)] <= data_b;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(n_push);
            rd_ptr <= rd_ptr + PW'(do_pop);
            used   <= used + n_push - CW'(do_pop);
        end
    end

endmodule

// File: rtl/scbf_counter_bank.sv
module scbf_counter_bank
    import scbf_pkg::*;
#(
    parameter int N      = 1024,
    parameter int THRESH = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 apply,
    input  op_e                  op,
    input  logic [$clog2(N)-1:0] idx,
    output logic                 vec_set,
    output logic                 vec_clr,
    output logic [$clog2(N)-1:0] vec_idx,
    output logic                 over_thresh
);
    localparam int DW = $clog2(N + 1);

    logic [CNT_W-1:0] cnt [N];
    logic [N-1:0]     retired;
    logic [DW-1:0]    retired_n;
    step_t            stp;

    always_comb stp = cnt_step(op, cnt[idx], retired[idx]);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            for (int i = 0; i < N; i++) cnt[i] <= '0;
            retired   <= '0;
            retired_n <= '0;
            vec_set   <= 1'b0;
            vec_clr   <= 1'b0;
            vec_idx   <= '0;
        end else begin
            vec_set <= apply && stp.set_bit;
            vec_clr <= apply && stp.clr_bit;
            vec_idx <= idx;
            if (apply && stp.write) cnt[idx] <= stp.next;
            if (apply && stp.retire) begin
                retired[idx] <= 1'b1;
                retired_n    <= retired_n + DW'(1);
            end
        end
    end

    assign over_thresh = (retired_n >= DW'(THRESH));

endmodule

// File: rtl/scbf_presence_vec.sv
module scbf_presence_vec #(
    parameter int N = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic                 upd_set,
    input  logic                 upd_clr,
    input  logic [$clog2(N)-1:0] upd_idx,
    input  logic                 rd_valid,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic                 rd_resp,
    output logic                 rd_absent
);
    logic [N-1:0] bits;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            bits <= '0;
        end else if (upd_set) begin
            bits[upd_idx] <= 1'b1;
        end else if (upd_clr) begin
            bits[upd_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_resp   <= 1'b0;
            rd_absent <= 1'b0;
        end else begin
            rd_resp   <= rd_valid;
            rd_absent <= rd_valid && !bits[rd_idx];
        end
    end

endmodule

// File: rtl/scbf_filter.sv
module scbf_filter
    import scbf_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int LINE_BYTES   = 64,
    parameter int N_ENTRIES    = 1024,
    parameter int FIFO_DEPTH   = 8,
    parameter int FLUSH_THRESH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_valid,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              q_resp_valid,
    output logic              q_absent,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              del_valid,
    input  logic [ADDR_W-1:0] del_addr,
    input  logic              slow_tick,
    output logic              flush_req,
    input  logic              flush_ack
);
    localparam int OFS_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(N_ENTRIES);
    localparam int EW    = IDX_W + 1;
    localparam int TOP_B = OFS_W + IDX_W;

    logic [IDX_W-1:0] q_idx, ins_idx, del_idx, head_idx, vec_idx;
    logic [EW-1:0]    head;
    logic             fifo_empty, lost_evt, lost_q, over_thresh;
    logic             flush_go, pop, vec_set, vec_clr;
    op_e              head_op;
    logic             unused_addr_bits;

    assign q_idx   = q_addr[OFS_W +: IDX_W];
    assign ins_idx = ins_addr[OFS_W +: IDX_W];
    assign del_idx = del_addr[OFS_W +: IDX_W];
    assign unused_addr_bits = ^{q_addr[ADDR_W-1:TOP_B], q_addr[OFS_W-1:0],
                                ins_addr[ADDR_W-1:TOP_B], ins_addr[OFS_W-1:0],
                                del_addr[ADDR_W-1:TOP_B], del_addr[OFS_W-1:0]};

    assign flush_go = flush_ack && flush_req;
    assign pop      = slow_tick && !fifo_empty && !flush_go;
    assign head_op  = op_e'(head[EW-1]);
    assign head_idx = head[IDX_W-1:0];

    scbf_event_fifo #(.EW(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk    (clk),
        .rst    (rst),
        .push_a (ins_valid),
        .data_a ({OP_INS, ins_idx}),
        .push_b (del_valid),
        .data_b ({OP_DEL, del_idx}),
        .pop    (pop),
        .head   (head),
        .empty  (fifo_empty),
        .lost   (lost_evt)
    );

    scbf_counter_bank #(.N(N_ENTRIES), .THRESH(FLUSH_THRESH)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush_go),
        .apply       (pop),
        .op          (head_op),
        .idx         (head_idx),
        .vec_set     (vec_set),
        .vec_clr     (vec_clr),
        .vec_idx     (vec_idx),
        .over_thresh (over_thresh)
    );

    scbf_presence_vec #(.N(N_ENTRIES)) u_vec (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_go),
        .upd_set   (vec_set),
        .upd_clr   (vec_clr),
        .upd_idx   (vec_idx),
        .rd_valid  (q_valid),
        .rd_idx    (q_idx),
        .rd_resp   (q_resp_valid),
        .rd_absent (q_absent)
    );

    always_ff @(posedge clk) begin
        if (rst) lost_q <= 1'b0;
        else     lost_q <= (lost_q && !flush_go) || lost_evt;
    end

    assign flush_req = over_thresh || lost_q;

endmodule

// File: rtl/scbf_filter_chk.sv
module scbf_filter_chk (
    input logic clk,
    input logic rst,
    input logic q_valid,
    input logic q_resp_valid,
    input logic q_absent,
    input logic flush_req,
    input logic flush_ack,
    input logic vec_set,
    input logic vec_clr,
    input logic lost_evt
);
    a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> q_resp_valid);

    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !q_valid |=> !q_resp_valid);

    a_r2_absent_with_resp: assert property (@(posedge clk) disable iff (rst)
        q_absent |-> q_resp_valid);

    a_r5_set_clr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(vec_set && vec_clr));

    a_r9_drop_raises_flush: assert property (@(posedge clk) disable iff (rst)
        lost_evt |=> flush_req);

    a_r8_flush_req_held: assert property (@(posedge clk) disable iff (rst)
        (flush_req && !flush_ack) |=> flush_req);

    a_r10_flush_drops_req: assert property (@(posedge clk) disable iff (rst)
        (flush_req && flush_ack && !lost_evt) |=> !flush_req);
endmodule

bind scbf_filter scbf_filter_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .q_valid      (q_valid),
    .q_resp_valid (q_resp_valid),
    .q_absent     (q_absent),
    .flush_req    (flush_req),
    .flush_ack    (flush_ack),
    .vec_set      (vec_set),
    .vec_clr      (vec_clr),
    .lost_evt     (lost_evt)
);

// File: tb/scbf_filter_test.sv
`timescale 1ns/1ps
module scbf_filter_test;
    localparam int N  = 1024;
    localparam int FD = 8;
    localparam int TH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        q_valid = 1'b0, ins_valid = 1'b0, del_valid = 1'b0;
    logic        slow_tick = 1'b0, flush_ack = 1'b0;
    logic [31:0] q_addr = '0, ins_addr = '0, del_addr = '0;
    logic        q_resp_valid, q_absent, flush_req;

    int chk_n = 0, err_n = 0;
    bit done = 0;

    int ref_cnt [N];
    bit ref_dead [N];
    int ref_dn = 0;
    bit ref_lost = 0;
    int mq [$];

    always #10 clk = ~clk;

    scbf_filter uut (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_addr(q_addr),
        .q_resp_valid(q_resp_valid), .q_absent(q_absent),
        .ins_valid(ins_valid), .ins_addr(ins_addr),
        .del_valid(del_valid), .del_addr(del_addr),
        .slow_tick(slow_tick), .flush_req(flush_req), .flush_ack(flush_ack)
    );

    function automatic logic [31:0] mk_addr(int idx);
        logic [31:0] a;
        a = $urandom;
        a[15:6] = idx[9:0];
        return a;
    endfunction

    function automatic bit exp_absent(int idx);
        return !ref_dead[idx] && ref_cnt[idx] == 0;
    endfunction

    function automatic bit exp_flush();
        return (ref_dn >= TH) || ref_lost;
    endfunction

    task automatic check(bit cond, string tag, int got, int exp);
        chk_n++;
        if (!cond) begin
            err_n++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic model_apply(int e);
        int i;
        i = e & 16'hFFFF;
        if (ref_dead[i]) return;
        if (e >= 65536) begin
            if (ref_cnt[i] == 7) begin ref_dead[i] = 1; ref_dn++; end
            else ref_cnt[i]++;
        end else if (ref_cnt[i] > 0) ref_cnt[i]--;
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin ref_cnt[i] = 0; ref_dead[i] = 0; end
        ref_dn = 0;
        ref_lost = 0;
    endtask

    task automatic push2(bit di, logic [31:0] ia, bit dd, logic [31:0] da);
        @(negedge clk);
        ins_valid = di; ins_addr = ia; del_valid = dd; del_addr = da;
        if (di) begin
            if (mq.size() < FD) mq.push_back(65536 + int'(ia[15:6]));
            else ref_lost = 1;
        end
        if (dd) begin
            if (mq.size() < FD) mq.push_back(int'(da[15:6]));
            else ref_lost = 1;
        end
        @(negedge clk);
        ins_valid = 0; del_valid = 0;
    endtask

    task automatic ins(int idx); push2(1, mk_addr(idx), 0, '0); endtask
    task automatic del(int idx); push2(0, '0, 1, mk_addr(idx)); endtask

    task automatic tick();
        @(negedge clk);
        slow_tick = 1;
        if (mq.size() > 0) model_apply(mq.pop_front());
        @(negedge clk);
        slow_tick = 0;
        @(negedge clk);
    endtask

    task automatic query_a(logic [31:0] a, string tag);
        bit e;
        e = exp_absent(int'(a[15:6]));
        @(negedge clk);
        q_valid = 1; q_addr = a;
        @(negedge clk);
        q_valid = 0;
        check(q_resp_valid == 1'b1, {tag, " resp_valid"}, int'(q_resp_valid), 1);
        check(q_absent == e, {tag, " absent"}, int'(q_absent), int'(e));
    endtask

    task automatic query(int idx, string tag); query_a(mk_addr(idx), tag); endtask

    task automatic chk_flush(string tag);
        check(flush_req == exp_flush(), {tag, " flush_req"}, int'(flush_req), int'(exp_flush()));
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_ack = 1;
        if (exp_flush()) model_clear();
        @(negedge clk);
        flush_ack = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            err_n++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", chk_n, err_n);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R3: reset state
        check(flush_req == 1'b0, "R3 flush_req after reset", int'(flush_req), 0);
        check(q_resp_valid == 1'b0, "R2 idle resp_valid", int'(q_resp_valid), 0);
        query(5, "R3 idx5");
        query(1023, "R3 idx1023");

        // R1: only index field hashed
        push2(1, 32'hABCD_0000 | (32'd10 << 6) | 32'h3F, 0, '0);
        tick();
        query_a(32'h1234_0000 | (32'd10 << 6), "R1 same idx other bits");
        query(11, "R1 neighbour idx");

        // R4: one event per tick, oldest first
        ins(20);
        ins(21);
        tick();
        query(20, "R4 first applied");
        query(21, "R4 second pending");
        tick();
        query(21, "R4 second applied");

        // R5: counting
        ins(30); ins(30); tick(); tick();
        del(30); tick();
        query(30, "R5 still counted");
        del(30); tick();
        query(30, "R5 cleared");

        // R6: delete at zero ignored
        del(40); tick();
        ins(40); tick();
        query(40, "R6 after ignored delete");
        del(40); tick();
        query(40, "R6 back to empty");

        // R7: insert queued before delete
        push2(1, mk_addr(50), 1, mk_addr(50));
        tick();
        query(50, "R7 insert first");
        tick();
        query(50, "R7 delete second");

        // R11: ack without request ignored
        ins(60); tick();
        do_flush();
        query(60, "R11 ack ignored");
        chk_flush("R11");

        // R8: saturation and retirement
        for (int k = 0; k < TH; k++) begin
            for (int j = 0; j < 8; j++) begin ins(100 + k); tick(); end
            chk_flush("R8 retire count");
            if (k == 0) begin
                for (int j = 0; j < 8; j++) begin del(100); tick(); end
                query(100, "R8 retired held present");
            end
        end

        // R10: flush clears everything
        do_flush();
        chk_flush("R10 after flush");
        query(100, "R10 retired cleared");
        query(60, "R10 counter cleared");
        query(10, "R10 vector cleared");

        // R9: overflow drops events and forces flush; queued events survive flush
        for (int p = 0; p < 5; p++) push2(1, mk_addr(200 + 2 * p), 1, mk_addr(201 + 2 * p));
        chk_flush("R9 overflow");
        check(ref_lost == 1'b1, "R9 model lost", int'(ref_lost), 1);
        do_flush();
        chk_flush("R9 after flush");
        for (int j = 0; j < FD; j++) tick();
        query(200, "R9 queued insert kept");
        query(208, "R9 dropped insert");

        // random mix over colliding indices
        for (int it = 0; it < 600; it++) begin
            int r, idx;
            r = $urandom % 10;
            idx = 300 + ($urandom % 12);
            if (mq.size() >= FD - 1) r = 7;
            if (r < 4) ins(idx);
            else if (r < 7) del(idx);
            else if (r < 9) begin
                tick();
                query(300 + ($urandom % 12), "R5 random lookup");
                chk_flush("R8 random flush");
                if (exp_flush()) do_flush();
            end else push2(1, mk_addr(idx), 1, mk_addr(300 + ($urandom % 12)));
        end
        for (int j = 0; j < FD; j++) tick();
        for (int i = 300; i < 312; i++) query(i, "R4 random drain");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", chk_n, err_n);
        $finish;
    end
endmodule